// File: doc/BRIEF.md
# Preemptive CAMAC Cycle Arbiter

This block feeds single CAMAC cycles to the crate-cycle engine of one cable. Firmware pushes cycles into one of two queues, one for ordinary traffic and one for real-time traffic. Each cycle carries a station, a subaddress, a function code, write data and a handful of control flags. A run of cycles ending with a cycle marked `last` forms one packet, which is one block transfer. As soon as the cable has nothing to do, the block starts on the head packet and offers its cycles one at a time over a valid/ready handshake.

A waiting real-time packet may suspend an ordinary packet. This happens only at a cycle boundary that the ordinary packet allows. Every real-time packet queued at that point then runs to completion, in arrival order. Before the suspended packet continues, the arbiter re-sends that packet's most recent setup write, for example an address pointer load. The data of this re-sent write is advanced by the number of data cycles already completed since the setup. Two kinds of lock prevent suspension. One flag locks the boundary after a single cycle, so that the two 16-bit halves of a 32-bit word stay together. Another flag, on a packet's first cycle, locks the whole packet.

Every finished packet produces a single-cycle status pulse. The pulse carries the packet tag, which queue the packet came from, the number of its own cycles that were issued, and a bit that shows whether the packet was ever suspended.

Top module: `camac_xfer_arb`

## Requirements
- R1: After reset, no cycle is offered (`cyc_valid`=0), no status is pulsed, and `enq_ready` is 1 for both queues.
- R2: The cycles of an ordinary packet are offered in queue order with their station, subaddress, function and data unchanged. One cycle after the `last` cycle is accepted, `st_valid` pulses once with the packet's tag, `st_rt`=0 and `st_cycles` equal to the packet length.
- R3: If a real-time packet is waiting, an ordinary packet that has had at least one cycle accepted is suspended at the first cycle boundary that has no lock. Every real-time packet already queued then completes, in arrival order, before the ordinary packet resumes. A real-time packet is never suspended.
- R4: On resume, if the suspended packet had issued a setup cycle (`enq_setup`=1), that cycle is offered again with `cyc_replay`=1. It keeps the same station, subaddress and function, and its data equals the setup data plus the number of data cycles (`enq_dat`=1) accepted after the setup.
- R5: If the suspended packet had issued no setup cycle, it resumes with its next cycle and sends no replay.
- R6: No suspension takes place at the boundary directly after a cycle that is marked `enq_hold`=1.
- R7: If the first cycle of a packet has `enq_nopre`=1, the whole packet runs with no suspension.
- R8: `st_preempted` is 1 only for an ordinary packet that was suspended. `st_cycles` does not count replay cycles.
- R9: Once a cycle is offered, `cyc_valid` and all cycle fields stay unchanged until `cyc_ready` accepts the cycle.
- R10: `enq_ready` is 0 while the queue chosen by `enq_rt` holds DEPTH cycles. The other queue is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Push one cycle into a queue |
| enq_rt | input | 1 | 1 selects the real-time queue, 0 the ordinary queue |
| enq_ready | output | 1 | The selected queue can take a cycle |
| enq_tag | input | TAG_W | Packet tag |
| enq_stn | input | 5 | Station number |
| enq_sub | input | 4 | Subaddress |
| enq_fn | input | 5 | Function code |
| enq_data | input | DW | Write data |
| enq_last | input | 1 | Final cycle of the packet |
| enq_setup | input | 1 | Setup write that is replayed on resume |
| enq_dat | input | 1 | Data cycle that advances the replay data |
| enq_hold | input | 1 | Lock the boundary after this cycle |
| enq_nopre | input | 1 | On a first cycle: lock the whole packet |
| cyc_valid | output | 1 | A cycle is offered |
| cyc_ready | input | 1 | The engine accepts the offered cycle |
| cyc_stn | output | 5 | Offered station |
| cyc_sub | output | 4 | Offered subaddress |
| cyc_fn | output | 5 | Offered function code |
| cyc_data | output | DW | Offered write data |
| cyc_replay | output | 1 | The offered cycle is a replayed setup write |
| st_valid | output | 1 | Completion pulse |
| st_rt | output | 1 | The completed packet came from the real-time queue |
| st_tag | output | TAG_W | Tag of the completed packet |
| st_cycles | output | CW | Cycles issued for the packet, replays not counted |
| st_preempted | output | 1 | The packet was suspended at least once |

## Verification
The bench builds the block with DW=16, TAG_W=4, CW=6 and DEPTH=8. With a depth of 8, a six-cycle ordinary packet and two two-cycle real-time packets fit side by side, and a single queue can be filled to capacity in a few pushes. With this setup the bench sweeps every suspension point of the six-cycle packet. It tries each point with the setup write placed before and after that point, and with the whole-packet lock on and off. For every combination it computes the expected issue order, the replay data and the completion words arithmetically.

// File: rtl/camac_xfer_pkg.sv
package camac_xfer_pkg;
    localparam int STN_W = 5;
    localparam int SUB_W = 4;
    localparam int FN_W  = 5;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_NRM  = 2'd1,
        M_RT   = 2'd2,
        M_RPL  = 2'd3
    } mode_e;

    // control flags of one queued cycle, most significant first
    typedef struct packed {
        logic nopre;
        logic hold;
        logic dat;
        logic setup;
        logic last;
    } cflag_t;

    localparam int FLAG_W = $bits(cflag_t);
endpackage

// File: rtl/camac_xfer_fifo.sv
module camac_xfer_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   LVL_MAX = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] IDX_MAX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wi;
        logic [AW-1:0] ri;
        logic [AW:0]   lvl;
    } fptr_t;

    fptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.lvl == LVL_MAX);
    assign empty   = (q.lvl == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[q.ri];

    always_comb begin
        d = q;
        if (do_push) d.wi = (q.wi == IDX_MAX) ? '0 : q.wi + 1'b1;
        if (do_pop)  d.ri = (q.ri == IDX_MAX) ? '0 : q.ri + 1'b1;
        if (do_push && !do_pop)      d.lvl = q.lvl + 1'b1;
        else if (do_pop && !do_push) d.lvl = q.lvl - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wi] <= din;
    end
endmodule

// File: rtl/camac_xfer_sched.sv
module camac_xfer_sched
    import camac_xfer_pkg::*;
#(
    parameter int DW    = 24,
    parameter int TAG_W = 4,
    parameter int CW    = 8,
    parameter int EW    = TAG_W + STN_W + SUB_W + FN_W + DW + FLAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EW-1:0]    n_head,
    input  logic             n_empty,
    output logic             n_pop,
    input  logic [EW-1:0]    r_head,
    input  logic             r_empty,
    output logic             r_pop,
    output logic             cyc_valid,
    input  logic             cyc_ready,
    output logic [STN_W-1:0] cyc_stn,
    output logic [SUB_W-1:0] cyc_sub,
    output logic [FN_W-1:0]  cyc_fn,
    output logic [DW-1:0]    cyc_data,
    output logic             cyc_replay,
    output logic             st_valid,
    output logic             st_rt,
    output logic [TAG_W-1:0] st_tag,
    output logic [CW-1:0]    st_cycles,
    output logic             st_preempted
);
    localparam int D_LO   = FLAG_W;
    localparam int FN_LO  = D_LO + DW;
    localparam int SUB_LO = FN_LO + FN_W;
    localparam int STN_LO = SUB_LO + SUB_W;
    localparam int TAG_LO = STN_LO + STN_W;

    typedef struct packed {
        mode_e            mode;
        logic             susp;     // an ordinary packet is suspended
        logic             pre;      // current ordinary packet was suspended
        logic             nopre;    // whole-packet lock
        logic             hold;     // boundary lock after last accepted cycle
        logic             stall;    // offer outstanding, not yet accepted
        logic             have_set; // setup write seen in ordinary packet
        logic [CW-1:0]    cnt;
        logic [CW-1:0]    rcnt;
        logic [STN_W-1:0] r_stn;
        logic [SUB_W-1:0] r_sub;
        logic [FN_W-1:0]  r_fn;
        logic [DW-1:0]    base;
        logic [DW-1:0]    dcnt;
        logic             sv;
        logic             srt;
        logic [TAG_W-1:0] stag;
        logic [CW-1:0]    scnt;
        logic             spre;
    } sst_t;

    sst_t q, d;

    cflag_t           nf, rf;
    logic [TAG_W-1:0] n_tag, r_tag;
    logic [STN_W-1:0] n_stn, r_stn;
    logic [SUB_W-1:0] n_sub, r_sub;
    logic [FN_W-1:0]  n_fn, r_fn;
    logic [DW-1:0]    n_data, r_data;
    logic             pre_now, hs;

    assign nf     = cflag_t'(n_head[FLAG_W-1:0]);
    assign n_data = n_head[D_LO +: DW];
    assign n_fn   = n_head[FN_LO +: FN_W];
    assign n_sub  = n_head[SUB_LO +: SUB_W];
    assign n_stn  = n_head[STN_LO +: STN_W];
    assign n_tag  = n_head[TAG_LO +: TAG_W];
    assign rf     = cflag_t'(r_head[FLAG_W-1:0]);
    assign r_data = r_head[D_LO +: DW];
    assign r_fn   = r_head[FN_LO +: FN_W];
    assign r_sub  = r_head[SUB_LO +: SUB_W];
    assign r_stn  = r_head[STN_LO +: STN_W];
    assign r_tag  = r_head[TAG_LO +: TAG_W];

    // suspension point: a boundary already passed, nothing outstanding, no lock
    assign pre_now = !r_empty && (q.cnt != '0) && !q.nopre && !q.hold && !q.stall;

    assign st_valid     = q.sv;
    assign st_rt        = q.srt;
    assign st_tag       = q.stag;
    assign st_cycles    = q.scnt;
    assign st_preempted = q.spre;

    always_comb begin
        d          = q;
        d.sv       = 1'b0;
        n_pop      = 1'b0;
        r_pop      = 1'b0;
        cyc_valid  = 1'b0;
        cyc_stn    = n_stn;
        cyc_sub    = n_sub;
        cyc_fn     = n_fn;
        cyc_data   = n_data;
        cyc_replay = 1'b0;
        hs         = 1'b0;
        unique case (q.mode)
            M_IDLE: begin
                if (!r_empty) begin
                    d.mode = M_RT;
                end else if (q.susp) begin
                    d.susp = 1'b0;
                    d.mode = q.have_set ? M_RPL : M_NRM;
                end else if (!n_empty) begin
                    d.mode = M_NRM;
                end
            end
            M_NRM: begin
                if (pre_now) begin
                    d.susp = 1'b1;
                    d.pre  = 1'b1;
                    d.mode = M_RT;
                end else begin
                    cyc_valid = !n_empty;
                    hs        = cyc_valid && cyc_ready;
                    if (hs) begin
                        n_pop  = 1'b1;
                        d.cnt  = q.cnt + 1'b1;
                        d.hold = nf.hold;
                        if (q.cnt == '0) d.nopre = nf.nopre;
                        if (nf.setup) begin
                            d.have_set = 1'b1;
                            d.r_stn    = n_stn;
                            d.r_sub    = n_sub;
                            d.r_fn     = n_fn;
                            d.base     = n_data;
                            d.dcnt     = '0;
                        end else if (nf.dat) begin
                            d.dcnt = q.dcnt + 1'b1;
                        end
                        if (nf.last) begin
                            d.sv       = 1'b1;
                            d.srt      = 1'b0;
                            d.stag     = n_tag;
                            d.scnt     = q.cnt + 1'b1;
                            d.spre     = q.pre;
                            d.cnt      = '0;
                            d.pre      = 1'b0;
                            d.nopre    = 1'b0;
                            d.hold     = 1'b0;
                            d.have_set = 1'b0;
                            d.mode     = M_IDLE;
                        end
                    end
                end
            end
            M_RT: begin
                cyc_valid = !r_empty;
                cyc_stn   = r_stn;
                cyc_sub   = r_sub;
                cyc_fn    = r_fn;
                cyc_data  = r_data;
                hs        = cyc_valid && cyc_ready;
                if (hs) begin
                    r_pop  = 1'b1;
                    d.rcnt = q.rcnt + 1'b1;
                    if (rf.last) begin
                        d.sv   = 1'b1;
                        d.srt  = 1'b1;
                        d.stag = r_tag;
                        d.scnt = q.rcnt + 1'b1;
                        d.spre = 1'b0;
                        d.rcnt = '0;
                        d.mode = M_IDLE;
                    end
                end
            end
            M_RPL: begin
                cyc_valid  = 1'b1;
                cyc_stn    = q.r_stn;
                cyc_sub    = q.r_sub;
                cyc_fn     = q.r_fn;
                cyc_data   = q.base + q.dcnt;
                cyc_replay = 1'b1;
                hs         = cyc_ready;
                if (hs) d.mode = M_NRM;
            end
            default: d.mode = M_IDLE;
        endcase
        d.stall = cyc_valid && !cyc_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/camac_xfer_arb.sv
module camac_xfer_arb
    import camac_xfer_pkg::*;
#(
    parameter int DW    = 24,
    parameter int TAG_W = 4,
    parameter int CW    = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic             enq_rt,
    output logic             enq_ready,
    input  logic [TAG_W-1:0] enq_tag,
    input  logic [4:0]       enq_stn,
    input  logic [3:0]       enq_sub,
    input  logic [4:0]       enq_fn,
    input  logic [DW-1:0]    enq_data,
    input  logic             enq_last,
    input  logic             enq_setup,
    input  logic             enq_dat,
    input  logic             enq_hold,
    input  logic             enq_nopre,
    output logic             cyc_valid,
    input  logic             cyc_ready,
    output logic [4:0]       cyc_stn,
    output logic [3:0]       cyc_sub,
    output logic [4:0]       cyc_fn,
    output logic [DW-1:0]    cyc_data,
    output logic             cyc_replay,
    output logic             st_valid,
    output logic             st_rt,
    output logic [TAG_W-1:0] st_tag,
    output logic [CW-1:0]    st_cycles,
    output logic             st_preempted
);
    localparam int EW   = TAG_W + STN_W + SUB_W + FN_W + DW + FLAG_W;
    localparam int NQ   = 2;   // index 0 ordinary, index 1 real-time

    logic [EW-1:0] enq_word;
    logic [EW-1:0] head [NQ];
    logic [NQ-1:0] push, pop, full, empty;

    assign enq_word  = {enq_tag, enq_stn, enq_sub, enq_fn, enq_data,
                        enq_nopre, enq_hold, enq_dat, enq_setup, enq_last};
    assign enq_ready = enq_rt ? !full[1] : !full[0];

    for (genvar g = 0; g < NQ; g++) begin : g_q
        assign push[g] = enq_valid && (enq_rt == 1'(g)) && !full[g];
        camac_xfer_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[g]),
            .din   (enq_word),
            .pop   (pop[g]),
            .dout  (head[g]),
            .full  (full[g]),
            .empty (empty[g])
        );
    end

    camac_xfer_sched #(.DW(DW), .TAG_W(TAG_W), .CW(CW), .EW(EW)) u_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .n_head       (head[0]),
        .n_empty      (empty[0]),
        .n_pop        (pop[0]),
        .r_head       (head[1]),
        .r_empty      (empty[1]),
        .r_pop        (pop[1]),
        .cyc_valid    (cyc_valid),
        .cyc_ready    (cyc_ready),
        .cyc_stn      (cyc_stn),
        .cyc_sub      (cyc_sub),
        .cyc_fn       (cyc_fn),
        .cyc_data     (cyc_data),
        .cyc_replay   (cyc_replay),
        .st_valid     (st_valid),
        .st_rt        (st_rt),
        .st_tag       (st_tag),
        .st_cycles    (st_cycles),
        .st_preempted (st_preempted)
    );
endmodule

// File: rtl/camac_xfer_arb_chk.sv
module camac_xfer_arb_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cyc_valid,
    input logic          cyc_ready,
    input logic [4:0]    cyc_stn,
    input logic [3:0]    cyc_sub,
    input logic [4:0]    cyc_fn,
    input logic [DW-1:0] cyc_data,
    input logic          cyc_replay,
    input logic          st_valid,
    input logic          st_rt,
    input logic          st_preempted
);
    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && !cyc_ready |=> cyc_valid && $stable(cyc_stn) && $stable(cyc_sub)
            && $stable(cyc_fn) && $stable(cyc_data) && $stable(cyc_replay)); // R9

    AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid); // R2

    AST_RT_NEVER_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_rt |-> !st_preempted); // R8

    AST_REPLAY_AFTER_RT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_replay) |-> $past(st_valid && st_rt)); // R4
endmodule

bind camac_xfer_arb camac_xfer_arb_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_valid    (cyc_valid),
    .cyc_ready    (cyc_ready),
    .cyc_stn      (cyc_stn),
    .cyc_sub      (cyc_sub),
    .cyc_fn       (cyc_fn),
    .cyc_data     (cyc_data),
    .cyc_replay   (cyc_replay),
    .st_valid     (st_valid),
    .st_rt        (st_rt),
    .st_preempted (st_preempted)
);

// File: tb/camac_xfer_arb_bench.sv
`timescale 1ns/1ps
module camac_xfer_arb_bench;
    localparam int DW = 16, TAG_W = 4, CW = 6, DEPTH = 8;
    localparam int NLEN = 6, BASE = 64, NTAG = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic enq_valid = 0, enq_rt = 0, enq_ready;
    logic [TAG_W-1:0] enq_tag = '0;
    logic [4:0] enq_stn = '0, enq_fn = '0;
    logic [3:0] enq_sub = '0;
    logic [DW-1:0] enq_data = '0;
    logic enq_last = 0, enq_setup = 0, enq_dat = 0, enq_hold = 0, enq_nopre = 0;
    logic cyc_valid, cyc_ready = 0, cyc_replay;
    logic [4:0] cyc_stn, cyc_fn;
    logic [3:0] cyc_sub;
    logic [DW-1:0] cyc_data;
    logic st_valid, st_rt, st_preempted;
    logic [TAG_W-1:0] st_tag;
    logic [CW-1:0] st_cycles;

    int checks = 0, errors = 0, wd = 0;
    int ln = 0, sn = 0;
    int lg_stn[32], lg_fn[32], lg_data[32], lg_rpl[32];
    int sg_tag[8], sg_cnt[8], sg_pre[8], sg_rt[8];
    int ex_stn[32], ex_fn[32], ex_data[32], ex_rpl[32];
    int en;

    always #2.5 clk = ~clk;

    camac_xfer_arb #(.DW(DW), .TAG_W(TAG_W), .CW(CW), .DEPTH(DEPTH)) u_camac_xfer_arb (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_rt(enq_rt), .enq_ready(enq_ready),
        .enq_tag(enq_tag), .enq_stn(enq_stn), .enq_sub(enq_sub), .enq_fn(enq_fn),
        .enq_data(enq_data), .enq_last(enq_last), .enq_setup(enq_setup), .enq_dat(enq_dat),
        .enq_hold(enq_hold), .enq_nopre(enq_nopre), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
        .cyc_stn(cyc_stn), .cyc_sub(cyc_sub), .cyc_fn(cyc_fn), .cyc_data(cyc_data),
        .cyc_replay(cyc_replay), .st_valid(st_valid), .st_rt(st_rt), .st_tag(st_tag),
        .st_cycles(st_cycles), .st_preempted(st_preempted));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cyc_valid && cyc_ready && ln < 32) begin
            lg_stn[ln] = cyc_stn; lg_fn[ln] = cyc_fn;
            lg_data[ln] = cyc_data; lg_rpl[ln] = cyc_replay; ln++;
        end
        if (st_valid && sn < 8) begin
            sg_tag[sn] = st_tag; sg_cnt[sn] = st_cycles;
            sg_pre[sn] = st_preempted; sg_rt[sn] = st_rt; sn++;
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push(input bit rt, input int tag, input int stn, input int sub, input int fn,
                        input int data, input bit last, input bit setup, input bit dat,
                        input bit hold, input bit nopre);
        enq_valid = 1; enq_rt = rt; enq_tag = TAG_W'(tag); enq_stn = 5'(stn);
        enq_sub = 4'(sub); enq_fn = 5'(fn); enq_data = DW'(data); enq_last = last;
        enq_setup = setup; enq_dat = dat; enq_hold = hold; enq_nopre = nopre;
        @(posedge clk); #1;
        enq_valid = 0;
    endtask

    task automatic add_exp(input int stn, input int fn, input int data, input int rpl);
        ex_stn[en] = stn; ex_fn[en] = fn; ex_data[en] = data; ex_rpl[en] = rpl; en++;
    endtask

    // s: position of setup write, k: first unlocked boundary, np: whole-packet lock
    task automatic scenario(input int s, input int k, input bit np);
        bit susp;
        string tg;
        ln = 0; sn = 0; en = 0;
        cyc_ready = 0;
        for (int i = 1; i <= NLEN; i++)
            push(0, NTAG, i, 2, (i == s) ? 16 : 0, (i == s) ? BASE : 200 + i,
                 i == NLEN, i == s, i > s, i < k, np && i == 1);
        repeat (3) @(posedge clk); #1;
        for (int p = 1; p <= 2; p++)
            for (int j = 1; j <= 2; j++)
                push(1, p, 20 + 2 * (p - 1) + j, 0, 8, 300 + 10 * p + j, j == 2, 0, 0, 0, 0);
        cyc_ready = 1;
        for (int t = 0; t < 300 && sn < 3; t++) @(posedge clk);
        repeat (4) @(posedge clk); #1;
        cyc_ready = 0;
        susp = !np && k < NLEN;
        tg = np ? "R7" : (susp ? (s <= k ? "R4" : "R5") : "R6");
        for (int i = 1; i <= (susp ? k : NLEN); i++)
            add_exp(i, (i == s) ? 16 : 0, (i == s) ? BASE : 200 + i, 0);
        for (int p = 1; p <= 2; p++)
            for (int j = 1; j <= 2; j++)
                add_exp(20 + 2 * (p - 1) + j, 8, 300 + 10 * p + j, 0);
        if (susp) begin
            if (s <= k) add_exp(s, 16, BASE + (k - s), 1);
            for (int i = k + 1; i <= NLEN; i++)
                add_exp(i, (i == s) ? 16 : 0, (i == s) ? BASE : 200 + i, 0);
        end
        chk(ln == en, {tg, " R3 issued cycle count"}, ln, en);
        for (int i = 0; i < en && i < ln; i++) begin
            chk(lg_stn[i] == ex_stn[i], {tg, " R2 R3 station order"}, lg_stn[i], ex_stn[i]);
            chk(lg_fn[i] == ex_fn[i], {tg, " R2 function"}, lg_fn[i], ex_fn[i]);
            chk(lg_data[i] == ex_data[i], {tg, " R4 data"}, lg_data[i], ex_data[i]);
            chk(lg_rpl[i] == ex_rpl[i], {tg, " R4 R5 replay flag"}, lg_rpl[i], ex_rpl[i]);
        end
        chk(sn == 3, "R2 status count", sn, 3);
        for (int i = 0; i < 3 && i < sn; i++) begin
            int nrm_pos;
            nrm_pos = susp ? 2 : 0;
            if (i == nrm_pos) begin
                chk(sg_tag[i] == NTAG && sg_rt[i] == 0, "R2 ordinary tag", sg_tag[i], NTAG);
                chk(sg_cnt[i] == NLEN, "R8 ordinary cycle count", sg_cnt[i], NLEN);
                chk(sg_pre[i] == int'(susp), {tg, " R8 preempted bit"}, sg_pre[i], int'(susp));
            end else begin
                int pk;
                pk = susp ? i + 1 : i;
                chk(sg_tag[i] == pk && sg_rt[i] == 1, "R3 real-time order", sg_tag[i], pk);
                chk(sg_cnt[i] == 2 && sg_pre[i] == 0, "R8 real-time status", sg_cnt[i], 2);
            end
        end
    endtask

    initial begin
        repeat (4) @(posedge clk); #1;
        chk(cyc_valid == 0, "R1 no offer in reset", cyc_valid, 0);
        chk(st_valid == 0, "R1 no status in reset", st_valid, 0);
        rst_n = 1;
        @(posedge clk); #1;
        chk(enq_ready == 1, "R1 ordinary queue ready", enq_ready, 1);
        enq_rt = 1; #0.5;
        chk(enq_ready == 1, "R1 real-time queue ready", enq_ready, 1);
        chk(cyc_valid == 0, "R1 idle after reset", cyc_valid, 0);
        enq_rt = 0;
        for (int np = 0; np < 2; np++)
            for (int s = 1; s <= 3; s += 2)
                for (int k = 1; k <= NLEN; k++)
                    scenario(s, k, np[0]);
        ln = 0; sn = 0; cyc_ready = 0;
        for (int i = 0; i < DEPTH; i++) push(0, i, i + 1, 1, 0, i, 1, 0, 0, 0, 0);
        enq_rt = 0; #0.5;
        chk(enq_ready == 0, "R10 ordinary queue full", enq_ready, 0);
        enq_rt = 1; #0.5;
        chk(enq_ready == 1, "R10 real-time queue independent", enq_ready, 1);
        enq_rt = 0;
        @(posedge clk); #1;
        cyc_ready = 1;
        for (int t = 0; t < 300 && sn < DEPTH; t++) @(posedge clk);
        repeat (3) @(posedge clk); #1;
        chk(ln == DEPTH, "R10 drained cycles", ln, DEPTH);
        for (int i = 0; i < DEPTH && i < sn; i++) begin
            chk(sg_tag[i] == i, "R2 one-cycle packet order", sg_tag[i], i);
            chk(sg_cnt[i] == 1, "R2 one-cycle count", sg_cnt[i], 1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule